// File: doc/BRIEF.md
# Floating-Point Rounding and Flag Policy Controller

This block sits ahead of a floating-point execute stage and settles, for each add, subtract or multiply, how the arithmetic is to be carried out. Every instruction arrives with a valid bit, an operation class, a 3-bit rounding field from the encoding, the architectural dynamic rounding mode, an IEEE-emulation enable and a signal that says an interrupt handler is running. The block returns one registered slot with the following controls:

- the rounding mode to apply;
- whether to round a binary64 result to binary32 precision;
- whether denormals are treated as zero and flushed to zero;
- whether the datapath's exception flags may update the user-visible state;
- whether an emulation trap is requested;
- whether the encoding is illegal.

The datapath reports raw exception flags for the slot that is currently presented. The block folds them into five sticky bits, and only an explicit clear resets them. There are three operation classes. One class always rounds to nearest-even and never touches the flags. One class follows the rounding field and accumulates flags. One class works at reduced precision and never touches the flags. While an interrupt handler runs, the flags are frozen, traps are suppressed and denormal handling is forced to zero.

Top module: `fpRoundPolicy`

## Requirements
- R1: While `rstN` is low, every output is 0, including `stickyFlags`.
- R2: Outputs appear one clock after the inputs are sampled. A cycle with `instValid` low produces `outValid`=0 and all other slot outputs 0, whatever the other inputs are.
- R3: `opClass` encodes the class: 0 is fixed rounding, 1 is dynamic rounding, 2 is reduced precision and 3 is reserved (illegal). The fixed class gives `outRm`=0 (nearest-even) and `outFlagWrite`=0, whatever the rounding field and the dynamic mode hold.
- R4: For classes 1 and 2, rounding-field codes 0 to 4 map directly onto `outRm` as 0 to 4. These are nearest-even, toward zero, down, up and nearest-max-magnitude. Codes 5 and 6 set `outIllegal`.
- R5: Rounding-field code 7 selects `dynRm`. If `dynRm` is 5, 6 or 7, `outIllegal` is set.
- R6: `outFlagWrite` is 1 exactly for a valid, legal dynamic-class instruction while `irqActive` is low.
- R7: `outReducePrec` is 1 exactly for a valid, legal reduced-precision instruction. That class never sets `outFlagWrite`.
- R8: While `irqActive` is high, a valid slot has `outDazFtz`=1, `outFlagWrite`=0 and `outEmuTrap`=0. Otherwise `outDazFtz` is 0.
- R9: `outEmuTrap` is 1 exactly when `outFlagWrite` is 1 and `emuEnable` was 1 for that instruction. A trap never comes from a slot with `instValid` low.
- R10: An illegal slot has `outRm`=0, `outReducePrec`=0, `outFlagWrite`=0 and `outEmuTrap`=0.
- R11: `stickyFlags` bits are [4] invalid, [3] divide-by-zero, [2] overflow, [1] underflow and [0] inexact. On a clock where `outFlagWrite` is 1, `dpFlags` is ORed into them and the result is visible after that clock. `clearFlags` zeroes them and takes precedence over a concurrent OR.
- R12: On a clock where `outFlagWrite` is 0 and `clearFlags` is 0, `stickyFlags` keeps its value whatever `dpFlags` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | An FP instruction is present this cycle |
| opClass | input | 2 | Operation class (0 fixed, 1 dynamic, 2 reduced, 3 reserved) |
| staticRm | input | 3 | Rounding field from the encoding |
| dynRm | input | 3 | Architectural dynamic rounding mode |
| emuEnable | input | 1 | IEEE-emulation trap enable |
| irqActive | input | 1 | An interrupt handler is running |
| dpFlags | input | 5 | Raw exception flags for the presented slot |
| clearFlags | input | 1 | Explicit write that clears the sticky flags |
| outValid | output | 1 | Registered slot valid |
| outRm | output | 3 | Effective rounding mode |
| outReducePrec | output | 1 | Round the result to binary32 precision |
| outDazFtz | output | 1 | Treat denormal inputs as zero and flush denormal results |
| outFlagWrite | output | 1 | Datapath flags may update the sticky state |
| outEmuTrap | output | 1 | Emulation trap request |
| outIllegal | output | 1 | Illegal encoding or reserved dynamic mode |
| stickyFlags | output | 5 | Accumulated exception flags |

## Verification
The main hazard is a trap or flag write leaking out of an empty slot. An empty slot must not inherit leftover data, or it would raise spurious traps. The bench therefore follows every instruction with an idle cycle whose other inputs still hold the previous instruction's values. The sweep covers every class, rounding field, dynamic mode, enable and handler state. It catches a fixed class that obeys the dynamic mode, a reserved code that passes through as a mode, and a handler that leaks flags. The sticky check pairs a clear with a concurrent flag write, so a design where the OR wins over the clear is caught. It also offers flags on slots that must not write, which catches a register that ignores the write enable.

// File: rtl/fpRoundPkg.sv
package fpRoundPkg;
  localparam int RM_W    = 3;
  localparam int CLASS_W = 2;
  localparam int FLAG_W  = 5;
  localparam int RM_LEGAL_MAX = 4;

  typedef enum logic [CLASS_W-1:0] {
    CLS_FIXED   = 2'd0,
    CLS_DYNAMIC = 2'd1,
    CLS_REDUCED = 2'd2,
    CLS_RSVD    = 2'd3
  } opClassT;

  localparam logic [RM_W-1:0] RM_RNE     = 3'd0;
  localparam logic [RM_W-1:0] RM_DYN_SEL = 3'd7;

  typedef struct packed {
    logic            valid;
    logic [RM_W-1:0] rm;
    logic            reduce;
    logic            dazFtz;
    logic            flagWr;
    logic            trap;
    logic            illegal;
  } slotStrobeT;
endpackage

// File: rtl/fpRoundCtrl.sv
module fpRoundCtrl
  import fpRoundPkg::*;
(
  input  logic               instValid,
  input  logic [CLASS_W-1:0] opClass,
  input  logic [RM_W-1:0]    staticRm,
  input  logic [RM_W-1:0]    dynRm,
  input  logic               emuEnable,
  input  logic               irqActive,
  output slotStrobeT         strobe
);
  logic [RM_W-1:0] codeSel;
  logic            codeBad;
  logic            classBad;
  logic            isFixed;
  logic            isDynamic;
  logic            isReduced;
  logic            legal;
  logic [RM_W-1:0] decodedRm;

  always_comb begin
    isFixed   = (opClass == CLS_FIXED);
    isDynamic = (opClass == CLS_DYNAMIC);
    isReduced = (opClass == CLS_REDUCED);
    classBad  = (opClass == CLS_RSVD);
  end

  // Code 7 redirects to the architectural mode.
  always_comb begin
    codeSel = (staticRm == RM_DYN_SEL) ? dynRm : staticRm;
    codeBad = (codeSel > RM_W'(RM_LEGAL_MAX));
  end

  always_comb begin
    if (classBad)     legal = 1'b0;
    else if (isFixed) legal = 1'b1;
    else              legal = !codeBad;
  end

  always_comb begin
    if (!legal || isFixed) decodedRm = RM_RNE;
    else                   decodedRm = codeSel;
  end

  always_comb begin
    strobe = '0;
    if (instValid) begin
      strobe.valid   = 1'b1;
      strobe.illegal = !legal;
      strobe.rm      = decodedRm;
      strobe.reduce  = legal && isReduced;
      strobe.dazFtz  = irqActive;
      strobe.flagWr  = legal && isDynamic && !irqActive;
      strobe.trap    = legal && isDynamic && !irqActive && emuEnable;
    end
  end
endmodule

// File: rtl/fpRoundDatapath.sv
module fpRoundDatapath
  import fpRoundPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  slotStrobeT        strobe,
  input  logic [FLAG_W-1:0] dpFlags,
  input  logic              clearFlags,
  output slotStrobeT        slotQ,
  output logic [FLAG_W-1:0] stickyQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slotQ <= '0;
    else       slotQ <= strobe;
  end

  // One sticky cell per exception bit.
  for (genvar b = 0; b < FLAG_W; b++) begin : gSticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                            stickyQ[b] <= 1'b0;
      else if (clearFlags)                  stickyQ[b] <= 1'b0;
      else if (slotQ.flagWr && dpFlags[b])  stickyQ[b] <= 1'b1;
    end
  end
endmodule

// File: rtl/fpRoundPolicy.sv
module fpRoundPolicy
  import fpRoundPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic [1:0]  opClass,
  input  logic [2:0]  staticRm,
  input  logic [2:0]  dynRm,
  input  logic        emuEnable,
  input  logic        irqActive,
  input  logic [4:0]  dpFlags,
  input  logic        clearFlags,
  output logic        outValid,
  output logic [2:0]  outRm,
  output logic        outReducePrec,
  output logic        outDazFtz,
  output logic        outFlagWrite,
  output logic        outEmuTrap,
  output logic        outIllegal,
  output logic [4:0]  stickyFlags
);
  slotStrobeT strobe;
  slotStrobeT slotQ;

  fpRoundCtrl uCtrl (
    .instValid (instValid),
    .opClass   (opClass),
    .staticRm  (staticRm),
    .dynRm     (dynRm),
    .emuEnable (emuEnable),
    .irqActive (irqActive),
    .strobe    (strobe)
  );

  fpRoundDatapath uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dpFlags    (dpFlags),
    .clearFlags (clearFlags),
    .slotQ      (slotQ),
    .stickyQ    (stickyFlags)
  );

  assign outValid      = slotQ.valid;
  assign outRm         = slotQ.rm;
  assign outReducePrec = slotQ.reduce;
  assign outDazFtz     = slotQ.dazFtz;
  assign outFlagWrite  = slotQ.flagWr;
  assign outEmuTrap    = slotQ.trap;
  assign outIllegal    = slotQ.illegal;
endmodule

// File: rtl/fpRoundPolicyChk.sv
module fpRoundPolicyChk (
  input logic       clk,
  input logic       rstN,
  input logic       instValid,
  input logic [1:0] opClass,
  input logic       emuEnable,
  input logic       irqActive,
  input logic [4:0] dpFlags,
  input logic       clearFlags,
  input logic       outValid,
  input logic [2:0] outRm,
  input logic       outReducePrec,
  input logic       outDazFtz,
  input logic       outFlagWrite,
  input logic       outEmuTrap,
  input logic       outIllegal,
  input logic [4:0] stickyFlags
);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(outFlagWrite || outEmuTrap || outReducePrec || outDazFtz || outIllegal));

  assert_fixed_rne_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outIllegal && $past(opClass) == 2'd0) |-> (outRm == 3'd0 && !outFlagWrite));

  assert_handler_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    outDazFtz |-> (!outFlagWrite && !outEmuTrap));

  assert_trap_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    outEmuTrap |-> ($past(instValid) && $past(emuEnable) && !$past(irqActive) && outFlagWrite));

  assert_illegal_inert_R10: assert property (@(posedge clk) disable iff (!rstN)
    outIllegal |-> (!outFlagWrite && !outEmuTrap && !outReducePrec && outRm == 3'd0));

  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    clearFlags |=> (stickyFlags == 5'd0));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!clearFlags && !outFlagWrite) |=> $stable(stickyFlags));
endmodule

bind fpRoundPolicy fpRoundPolicyChk uChk (
  .clk           (clk),
  .rstN          (rstN),
  .instValid     (instValid),
  .opClass       (opClass),
  .emuEnable     (emuEnable),
  .irqActive     (irqActive),
  .dpFlags       (dpFlags),
  .clearFlags    (clearFlags),
  .outValid      (outValid),
  .outRm         (outRm),
  .outReducePrec (outReducePrec),
  .outDazFtz     (outDazFtz),
  .outFlagWrite  (outFlagWrite),
  .outEmuTrap    (outEmuTrap),
  .outIllegal    (outIllegal),
  .stickyFlags   (stickyFlags)
);

// File: tb/fpRoundPolicy_test.sv
module fpRoundPolicy_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       instValid = 1'b0;
  logic [1:0] opClass = '0;
  logic [2:0] staticRm = '0;
  logic [2:0] dynRm = '0;
  logic       emuEnable = 1'b0;
  logic       irqActive = 1'b0;
  logic [4:0] dpFlags = '0;
  logic       clearFlags = 1'b0;
  logic       outValid, outReducePrec, outDazFtz, outFlagWrite, outEmuTrap, outIllegal;
  logic [2:0] outRm;
  logic [4:0] stickyFlags;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fpRoundPolicy uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opClass(opClass),
    .staticRm(staticRm), .dynRm(dynRm), .emuEnable(emuEnable),
    .irqActive(irqActive), .dpFlags(dpFlags), .clearFlags(clearFlags),
    .outValid(outValid), .outRm(outRm), .outReducePrec(outReducePrec),
    .outDazFtz(outDazFtz), .outFlagWrite(outFlagWrite), .outEmuTrap(outEmuTrap),
    .outIllegal(outIllegal), .stickyFlags(stickyFlags)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cls=%0d srm=%0d drm=%0d emu=%0d irq=%0d)",
               req, act, exp, opClass, staticRm, dynRm, emuEnable, irqActive);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int expSticky = 0;
    int iter = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid", outValid, 0);
    chk("R1 flagwrite", outFlagWrite, 0);
    chk("R1 trap", outEmuTrap, 0);
    chk("R1 sticky", stickyFlags, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 8; s++)
        for (int d = 0; d < 8; d++)
          for (int m = 0; m < 4; m++) begin
            int eRm, eIll, eFw, eTrap, eRed, eDaz, code, pat, doClr;
            bit emu = m[0];
            bit irq = m[1];
            // expected slot from the requirements
            eIll = 0; eRm = 0;
            if (c == 3) eIll = 1;
            else if (c != 0) begin
              code = (s == 7) ? d : s;
              if (code > 4) eIll = 1; else eRm = code;
            end
            eFw   = (!eIll && c == 1 && !irq) ? 1 : 0;
            eTrap = (eFw && emu) ? 1 : 0;
            eRed  = (!eIll && c == 2) ? 1 : 0;
            eDaz  = irq ? 1 : 0;

            instValid = 1'b1; opClass = c[1:0]; staticRm = s[2:0]; dynRm = d[2:0];
            emuEnable = emu; irqActive = irq; dpFlags = 5'h1f; clearFlags = 1'b0;
            @(negedge clk);
            chk("R2 valid", outValid, 1);
            chk((c == 0) ? "R3 rm" : (s == 7 ? "R5 rm" : "R4 rm"), outRm, eRm);
            chk((s == 7) ? "R5 illegal" : "R10 illegal", outIllegal, eIll);
            chk("R6 flagwrite", outFlagWrite, eFw);
            chk("R9 trap", outEmuTrap, eTrap);
            chk("R7 reduce", outReducePrec, eRed);
            chk("R8 dazftz", outDazFtz, eDaz);
            chk("R12 sticky", stickyFlags, expSticky);

            // idle slot with stale inputs, and flags for the presented slot
            pat   = (iter * 7 + 3) & 31;
            doClr = ((iter % 61) == 60) ? 1 : 0;
            instValid = 1'b0; dpFlags = pat[4:0]; clearFlags = doClr[0];
            if (doClr) expSticky = 0;
            else if (eFw) expSticky = expSticky | pat;
            @(negedge clk);
            chk(doClr ? "R11 clear" : (eFw ? "R11 accumulate" : "R12 hold"), stickyFlags, expSticky);
            chk("R2 idle valid", outValid, 0);
            chk("R2 idle trap", outEmuTrap, 0);
            chk("R2 idle flagwrite", outFlagWrite, 0);
            clearFlags = 1'b0;
            iter++;
          end
    // clear colliding with a flag-writing slot: clear wins
    instValid = 1'b1; opClass = 2'd1; staticRm = 3'd0; irqActive = 1'b0; emuEnable = 1'b0;
    @(negedge clk);
    chk("R6 flagwrite", outFlagWrite, 1);
    instValid = 1'b0; dpFlags = 5'h1f; clearFlags = 1'b1;
    @(negedge clk);
    chk("R11 clear precedence", stickyFlags, 0);
    clearFlags = 1'b0; dpFlags = 5'h0;
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule